// File: doc/BRIEF.md
# Even/Odd Page Translation Checker

This block finishes an address translation after the page-table cache lookup has finished. It takes the lookup outcome (hit or miss), the virtual address, the access kind (load or store), the matching entry's page-size mask and the entry's two page descriptors, one even and one odd. From these it produces either a physical address with a capability-permission flag, or an exception code. The page mask sets the page size. The page size in turn fixes which virtual-address bit chooses between the two descriptors, and where the frame number ends and the page offset begins.

A request is presented on `req_i` together with its operands. One clock later the registered result appears with `valid_o` high. The lookup itself and the handling of any exception are done outside the block. A mask pattern outside the supported set does not produce an address: it raises a separate error flag.

Top module: `page_xlate_check`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `pa_o`, `cap_o`, `exc_o` and `bad_mask_o` are all zero.
- R2: A request sampled with `req_i` high at a rising clock edge gives its result at that same edge, with `valid_o` high. A cycle sampled with `req_i` low drives all outputs to zero.
- R3: The legal mask values are 2^(2k)−1 for k = 0..8 (0x0000, 0x0003, … 0xffff). Each selects bit position 12+2k of the virtual address.
- R4: Each descriptor is 28 bits wide, laid out as [27:4] frame number, [3] dirty, [2] valid, [1] store capability, [0] load capability. The odd descriptor is used when the virtual-address bit at the select position is 1, and the even descriptor is used otherwise.
- R5: On success, bit j of `pa_o` equals `va_i[j]` for j below the select position. For j at or above it, bit j equals frame bit j−12. Bits with no frame bit behind them are zero.
- R6: When `hit_i` is low, `exc_o` is 1 for a load or 2 for a store. This overrides every other check.
- R7: On a hit with a legal mask and the chosen descriptor's valid bit clear, `exc_o` is 3 for a load or 4 for a store.
- R8: A store to a valid descriptor whose dirty bit is clear gives `exc_o` = 5. A load never gives code 5, and an invalid descriptor reports code 4 instead.
- R9: On success, `cap_o` is the chosen descriptor's store-capability bit for a store and its load-capability bit for a load.
- R10: On a hit with an illegal mask, `bad_mask_o` is 1 while `exc_o`, `pa_o` and `cap_o` are 0. On a miss, `bad_mask_o` is 0 whatever the mask.
- R11: Whenever `exc_o` is nonzero, `pa_o` and `cap_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request strobe |
| hit_i | input | 1 | Lookup found a matching entry |
| store_i | input | 1 | 1 = store access, 0 = load access |
| va_i | input | 64 | Virtual address |
| mask_i | input | 16 | Page-size mask of the matching entry |
| even_i | input | 28 | Even page descriptor |
| odd_i | input | 28 | Odd page descriptor |
| valid_o | output | 1 | Result valid |
| pa_o | output | 64 | Physical address |
| cap_o | output | 1 | Capability permission for this access |
| exc_o | output | 3 | Exception code, 0 = none |
| bad_mask_o | output | 1 | Illegal page mask on a hit |

## Verification
The assertions assume that every input is stable and known around the rising edge. They also assume that `req_i` is the only qualifier, so values on the other inputs while `req_i` is low must leave the outputs at zero. The bench drives all inputs on the falling edge and samples on the next falling edge, so each request is checked one register stage after it was sampled. The sweep covers every legal mask and both descriptor halves, with every combination of valid, dirty and access kind. It also covers several illegal masks on both hits and misses. The descriptor that is not selected always carries opposite flags and a different frame, so choosing the wrong half shows up in the outputs.

// File: rtl/tpx_pkg.sv
package tpx_pkg;
  typedef enum logic [2:0] {
    XC_NONE      = 3'd0,
    XC_REFILL_LD = 3'd1,
    XC_REFILL_ST = 3'd2,
    XC_INVAL_LD  = 3'd3,
    XC_INVAL_ST  = 3'd4,
    XC_MODIFY    = 3'd5
  } xc_e;
endpackage

// File: rtl/tpx_mask_decode.sv
module tpx_mask_decode #(
  parameter int MASK_W     = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int SEL_W      = 5
) (
  input  logic [MASK_W-1:0] mask_i,
  output logic              legal_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam int NSIZE = MASK_W/2 + 1;

  logic [NSIZE-1:0] size_hit;

  for (genvar k = 0; k < NSIZE; k++) begin : g_size
    localparam logic [MASK_W-1:0] PAT = ~({MASK_W{1'b1}} << (2*k));
    assign size_hit[k] = (mask_i == PAT);
  end

  always_comb begin
    legal_o = 1'b0;
    sel_o   = SEL_W'(PAGE_SHIFT);
    for (int k = 0; k < NSIZE; k++) begin
      if (size_hit[k]) begin
        legal_o = 1'b1;
        sel_o   = SEL_W'(PAGE_SHIFT + 2*k);
      end
    end
  end
endmodule

// File: rtl/tpx_page_pick.sv
module tpx_page_pick #(
  parameter int VA_W   = 64,
  parameter int DESC_W = 28,
  parameter int SEL_W  = 5
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DESC_W-1:0] even_i,
  input  logic [DESC_W-1:0] odd_i,
  output logic [DESC_W-1:0] desc_o
);
  logic use_odd;
  assign use_odd = va_i[sel_i];
  assign desc_o  = use_odd ? odd_i : even_i;
endmodule

// File: rtl/tpx_addr_form.sv
module tpx_addr_form #(
  parameter int VA_W       = 64,
  parameter int PA_W       = 64,
  parameter int PFN_W      = 24,
  parameter int PAGE_SHIFT = 12,
  parameter int SEL_W      = 5
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [PFN_W-1:0] pfn_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [PA_W-1:0]  pa_o
);
  logic [PA_W-1:0] low_mask;
  logic [PA_W-1:0] frame_part;

  // frame bits below the select position are dropped; offset fills them
  assign low_mask   = (PA_W'(1) << sel_i) - PA_W'(1);
  assign frame_part = PA_W'(pfn_i) << PAGE_SHIFT;
  assign pa_o       = (frame_part & ~low_mask) | (PA_W'(va_i) & low_mask);
endmodule

// File: rtl/page_xlate_check.sv
module page_xlate_check #(
  parameter int VA_W       = 64,
  parameter int PA_W       = 64,
  parameter int PFN_W      = 24,
  parameter int MASK_W     = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              hit_i,
  input  logic              store_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [PFN_W+3:0]  even_i,
  input  logic [PFN_W+3:0]  odd_i,
  output logic              valid_o,
  output logic [PA_W-1:0]   pa_o,
  output logic              cap_o,
  output logic [2:0]        exc_o,
  output logic              bad_mask_o
);
  import tpx_pkg::*;

  localparam int DESC_W = PFN_W + 4;
  localparam int SEL_W  = $clog2(PAGE_SHIFT + MASK_W + 1);

  logic              legal;
  logic [SEL_W-1:0]  sel;
  logic [DESC_W-1:0] desc;
  logic [PA_W-1:0]   pa_raw;
  logic [PFN_W-1:0]  pfn;
  logic              d_dirty, d_valid, d_cap_st, d_cap_ld;
  xc_e               xc_n;
  logic              bad_n;
  logic [PA_W-1:0]   pa_n;
  logic              cap_n;

  tpx_mask_decode #(.MASK_W(MASK_W), .PAGE_SHIFT(PAGE_SHIFT), .SEL_W(SEL_W)) u_dec (
    .mask_i (mask_i),
    .legal_o(legal),
    .sel_o  (sel)
  );

  tpx_page_pick #(.VA_W(VA_W), .DESC_W(DESC_W), .SEL_W(SEL_W)) u_pick (
    .va_i  (va_i),
    .sel_i (sel),
    .even_i(even_i),
    .odd_i (odd_i),
    .desc_o(desc)
  );

  assign pfn      = desc[DESC_W-1:4];
  assign d_dirty  = desc[3];
  assign d_valid  = desc[2];
  assign d_cap_st = desc[1];
  assign d_cap_ld = desc[0];

  tpx_addr_form #(.VA_W(VA_W), .PA_W(PA_W), .PFN_W(PFN_W),
                  .PAGE_SHIFT(PAGE_SHIFT), .SEL_W(SEL_W)) u_addr (
    .va_i (va_i),
    .pfn_i(pfn),
    .sel_i(sel),
    .pa_o (pa_raw)
  );

  // priority: miss, illegal mask, invalid, clean store
  always_comb begin
    xc_n  = XC_NONE;
    bad_n = 1'b0;
    if (!hit_i)                  xc_n  = store_i ? XC_REFILL_ST : XC_REFILL_LD;
    else if (!legal)             bad_n = 1'b1;
    else if (!d_valid)           xc_n  = store_i ? XC_INVAL_ST : XC_INVAL_LD;
    else if (store_i && !d_dirty) xc_n = XC_MODIFY;
  end

  always_comb begin
    pa_n  = '0;
    cap_n = 1'b0;
    if (hit_i && legal && xc_n == XC_NONE) begin
      pa_n  = pa_raw;
      cap_n = store_i ? d_cap_st : d_cap_ld;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      pa_o       <= '0;
      cap_o      <= 1'b0;
      exc_o      <= 3'd0;
      bad_mask_o <= 1'b0;
    end else if (req_i) begin
      valid_o    <= 1'b1;
      pa_o       <= pa_n;
      cap_o      <= cap_n;
      exc_o      <= xc_n;
      bad_mask_o <= bad_n;
    end else begin
      valid_o    <= 1'b0;
      pa_o       <= '0;
      cap_o      <= 1'b0;
      exc_o      <= 3'd0;
      bad_mask_o <= 1'b0;
    end
  end

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && exc_o == 3'd0 && pa_o == '0 && !bad_mask_o));

  assert_refill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hit_i) |=> (exc_o == ($past(store_i) ? 3'd2 : 3'd1) && !bad_mask_o));

  assert_exc_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o != 3'd0) |-> (pa_o == '0 && !cap_o));

  assert_bad_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_mask_o |-> (pa_o == '0 && exc_o == 3'd0 && !cap_o));

  assert_offset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && exc_o == 3'd0 && !bad_mask_o) |->
      pa_o[PAGE_SHIFT-1:0] == $past(va_i[PAGE_SHIFT-1:0]));

  assert_modify_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && exc_o == 3'd5) |-> $past(store_i));
endmodule

// File: tb/page_xlate_check_bench.sv
`timescale 1ns/1ps
module page_xlate_check_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, hit_i = 1'b0, store_i = 1'b0;
  logic [63:0] va_i = '0;
  logic [15:0] mask_i = '0;
  logic [27:0] even_i = '0, odd_i = '0;
  logic        valid_o, cap_o, bad_mask_o;
  logic [63:0] pa_o;
  logic [2:0]  exc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  page_xlate_check u_page_xlate_check (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .hit_i(hit_i), .store_i(store_i),
    .va_i(va_i), .mask_i(mask_i), .even_i(even_i), .odd_i(odd_i),
    .valid_o(valid_o), .pa_o(pa_o), .cap_o(cap_o), .exc_o(exc_o), .bad_mask_o(bad_mask_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_pa(input logic [63:0] va, input logic [23:0] pfn, input int sel);
    logic [63:0] r = '0;
    for (int j = 0; j < 64; j++) begin
      if (j < sel) r[j] = va[j];
      else if (j - 12 < 24) r[j] = pfn[j-12];
    end
    return r;
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic issue(input logic hit, input logic st, input logic [63:0] va, input logic [15:0] mask,
                       input logic [27:0] ev, input logic [27:0] od, input logic [63:0] e_pa,
                       input logic e_cap, input logic [2:0] e_exc, input logic e_bad, input string tag);
    req_i = 1'b1; hit_i = hit; store_i = st; va_i = va; mask_i = mask; even_i = ev; odd_i = od;
    @(negedge clk_i);
    chk({tag, " R2 valid"}, 64'(valid_o), 64'd1);
    chk({tag, " pa"}, pa_o, e_pa);
    chk({tag, " cap"}, 64'(cap_o), 64'(e_cap));
    chk({tag, " exc"}, 64'(exc_o), 64'(e_exc));
    chk({tag, " bad_mask"}, 64'(bad_mask_o), 64'(e_bad));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    chk("R1 reset valid", 64'(valid_o), 64'd0);
    chk("R1 reset pa", pa_o, 64'd0);
    chk("R1 reset exc", 64'(exc_o), 64'd0);
    chk("R1 reset cap/bad", 64'({cap_o, bad_mask_o}), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 R4 R5 R7 R8 R9 R11: full sweep over legal sizes
    for (int k = 0; k <= 8; k++) begin
      for (int odd = 0; odd < 2; odd++) begin
        for (int v = 0; v < 2; v++) begin
          for (int d = 0; d < 2; d++) begin
            for (int st = 0; st < 2; st++) begin
              int sel = 12 + 2*k;
              logic [15:0] mask = 16'((32'd1 << (2*k)) - 1);
              logic [63:0] va = 64'hA5C3_96E1_7B2D_4F38 ^ (64'(k) * 64'h0123_4567_89AB_CDEF);
              logic [23:0] pfn_s = 24'h5A3CE1 ^ 24'(k * 24'h01F3);
              logic [23:0] pfn_o = ~pfn_s;
              logic cs = 1'(d ^ odd ^ 1);
              logic cl = ~cs;
              logic [27:0] chosen, other;
              logic [63:0] e_pa;
              logic e_cap;
              logic [2:0] e_exc;
              va[sel] = 1'(odd);
              chosen = {pfn_s, 1'(d), 1'(v), cs, cl};
              other  = {pfn_o, ~1'(d), ~1'(v), ~cs, ~cl};
              if (v == 0)                 e_exc = st ? 3'd4 : 3'd3;
              else if (st == 1 && d == 0) e_exc = 3'd5;
              else                        e_exc = 3'd0;
              e_pa  = (e_exc == 0) ? model_pa(va, pfn_s, sel) : 64'd0;
              e_cap = (e_exc == 0) ? (st ? cs : cl) : 1'b0;
              issue(1'b1, 1'(st), va, mask, odd ? other : chosen, odd ? chosen : other,
                    e_pa, e_cap, e_exc, 1'b0,
                    $sformatf("R3 R4 R5 R7 R8 R9 R11 k=%0d odd=%0d v=%0d d=%0d st=%0d", k, odd, v, d, st));
            end
          end
        end
      end
    end

    // R10: illegal masks on a hit
    begin
      logic [15:0] bad_masks [5] = '{16'h0001, 16'h0007, 16'hFFFE, 16'h8000, 16'h0030};
      for (int i = 0; i < 5; i++) begin
        issue(1'b1, 1'(i & 1), 64'hFFFF_0000_1234_5678, bad_masks[i], 28'hFFFFFFF, 28'hFFFFFFF,
              64'd0, 1'b0, 3'd0, 1'b1, $sformatf("R10 illegal mask %h", bad_masks[i]));
      end
    end

    // R6: miss overrides everything, including an illegal mask
    issue(1'b0, 1'b0, 64'h0000_0000_0000_1000, 16'h0000, 28'hFFFFFFF, 28'hFFFFFFF,
          64'd0, 1'b0, 3'd1, 1'b0, "R6 miss load");
    issue(1'b0, 1'b1, 64'h0000_0000_0000_1000, 16'h0fff, 28'hFFFFFFF, 28'hFFFFFFF,
          64'd0, 1'b0, 3'd2, 1'b0, "R6 miss store");
    issue(1'b0, 1'b1, 64'h1, 16'h0005, 28'h0, 28'h0,
          64'd0, 1'b0, 3'd2, 1'b0, "R6 R10 miss with illegal mask");

    // R2: idle cycle with live operands gives zeros
    req_i = 1'b0; hit_i = 1'b1; store_i = 1'b0; mask_i = 16'h0000; even_i = 28'hFFFFFFF;
    @(negedge clk_i);
    chk("R2 idle valid", 64'(valid_o), 64'd0);
    chk("R2 idle pa", pa_o, 64'd0);
    chk("R2 idle exc/cap/bad", 64'({exc_o, cap_o, bad_mask_o}), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule